// File: doc/BRIEF.md
# Transmit DMA Process Sequencer

This block sequences the transmit side of a descriptor-driven Ethernet DMA engine. A run-enable control bit starts and stops the process. A poll-demand strobe, written by software, restarts descriptor processing after the engine has parked itself. Simple request/acknowledge handshakes stand in for three things: fetching a descriptor, reading frame data into the transmit buffer, and the MAC reporting that the frame has left. Bus mastering, descriptor memory and the MAC itself are outside the block.

The current process state is published as a fixed 3-bit code that software can read. A frame normally moves through fetch, read/queue, wait for end and close, then returns to fetch. When a descriptor still belongs to host software, or the data read underflows, the engine parks in a suspended state. Only a poll-demand write, or clearing run-enable, takes it out of that state. The block also gives one-cycle event pulses for transmit complete, underflow and process stopped.

Top module: `txdma_seq`

## Requirements
- R1: Synchronous active-high reset forces `state_code` to 0 on the next edge, with all requests and event pulses low. The state codes are 0 stopped, 1 fetch descriptor, 3 read/queue data, 2 wait for end of frame, 7 close descriptor and 6 suspended. No other code ever appears.
- R2: In stopped (0), `run_en` high moves the state to fetch (1) on the next edge. While `run_en` is low the state stays at 0.
- R3: `fetch_req` is high exactly while the state is 1. A `fetch_ack` that returns `fetch_own`=1 (descriptor owned by the engine) moves the state to read/queue (3).
- R4: A `fetch_ack` that returns `fetch_own`=0 (descriptor still owned by host software) moves the state to suspended (6).
- R5: `rd_req` is high exactly while the state is 3. Here `rd_uflow` moves the state to 6 and pulses `evt_underflow` for one cycle, in the cycle the state reads 6. It takes priority over `rd_ack`. Without an underflow, `rd_ack` moves the state to 2.
- R6: In state 2, `tx_done` moves the state to close (7).
- R7: Close lasts exactly one cycle, and `evt_txdone` is high exactly in that cycle. The state then goes to 1 if `run_en` is high, or to 0 if it is low.
- R8: Clearing `run_en` in state 3 or 2 does not stop the process; the stop takes effect from close. Clearing it in state 1 with no acknowledge present, or in state 6, gives state 0 on the next edge.
- R9: In state 6 with `run_en` high, the state holds until `poll_wr` is seen, which moves it to 1. A `poll_wr` in any other state has no effect on the state.
- R10: `evt_stopped` pulses for one cycle, in the first cycle the state reads 0 after being non-zero outside reset. Reset itself raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start/stop control bit |
| poll_wr | input | 1 | Poll-demand write strobe |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_ack | input | 1 | Descriptor fetch acknowledge |
| fetch_own | input | 1 | Ownership bit returned with the acknowledge (1 = engine) |
| rd_req | output | 1 | Frame data read request |
| rd_ack | input | 1 | Frame data read complete |
| rd_uflow | input | 1 | Buffer underflow during the data read |
| tx_done | input | 1 | MAC reports end of frame transmission |
| state_code | output | 3 | Encoded process state |
| evt_txdone | output | 1 | Transmit-complete pulse |
| evt_underflow | output | 1 | Underflow pulse |
| evt_stopped | output | 1 | Process-stopped pulse |

## Verification
The checker watches, on every cycle, the transitions that a single edge decides. These are: reset to stopped, start to fetch, host ownership and underflow to suspended, end of frame to close, close lasting one cycle, no stop mid-frame, suspended holding without a poll, and stopped pulses landing only in state 0. Some effects span several handshakes and only the bench's scenarios show them. Examples are a stop request made during the data read that takes effect only after close, a poll write being ignored outside suspended, and the absence of a stopped pulse when reset hits a running engine. For these the bench runs directed sequences and a long seeded random run against its own model of the state codes.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        TXS_STOP  = 3'd0,
        TXS_FETCH = 3'd1,
        TXS_WAIT  = 3'd2,
        TXS_READ  = 3'd3,
        TXS_SUSP  = 3'd6,
        TXS_CLOSE = 3'd7
    } txs_e;

    typedef struct packed {
        logic run_en;
        logic poll_wr;
        logic fetch_ack;
        logic fetch_own;
        logic rd_ack;
        logic rd_uflow;
        logic tx_done;
    } txin_t;

    typedef struct packed {
        logic txdone;
        logic underflow;
        logic stopped;
    } txevt_t;

    function automatic logic in_frame(txs_e s);
        return (s == TXS_READ) || (s == TXS_WAIT);
    endfunction

endpackage

// File: rtl/txdma_next.sv
module txdma_next
    import txdma_pkg::*;
(
    input  txs_e  cur,
    input  txin_t in,
    output txs_e  nxt,
    output logic  uflow_hit
);
    always_comb begin
        nxt       = cur;
        uflow_hit = 1'b0;
        unique case (cur)
            TXS_STOP:  if (in.run_en) nxt = TXS_FETCH;
            TXS_FETCH: begin
                if (in.fetch_ack)      nxt = in.fetch_own ? TXS_READ : TXS_SUSP;
                else if (!in.run_en)   nxt = TXS_STOP;
            end
            TXS_READ: begin
                if (in.rd_uflow) begin
                    nxt       = TXS_SUSP;
                    uflow_hit = 1'b1;
                end else if (in.rd_ack) begin
                    nxt = TXS_WAIT;
                end
            end
            TXS_WAIT:  if (in.tx_done) nxt = TXS_CLOSE;
            TXS_CLOSE: nxt = in.run_en ? TXS_FETCH : TXS_STOP;
            TXS_SUSP: begin
                if (!in.run_en)       nxt = TXS_STOP;
                else if (in.poll_wr)  nxt = TXS_FETCH;
            end
            default:   nxt = TXS_STOP;
        endcase
    end
endmodule

// File: rtl/txdma_events.sv
module txdma_events
    import txdma_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  txs_e   cur,
    input  txs_e   nxt,
    input  logic   uflow_hit,
    output txevt_t evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            evt.txdone    <= (nxt == TXS_CLOSE);
            evt.underflow <= uflow_hit;
            evt.stopped   <= (cur != TXS_STOP) && (nxt == TXS_STOP);
        end
    end
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
    import txdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic               poll_wr,
    output logic               fetch_req,
    input  logic               fetch_ack,
    input  logic               fetch_own,
    output logic               rd_req,
    input  logic               rd_ack,
    input  logic               rd_uflow,
    input  logic               tx_done,
    output logic [STATE_W-1:0] state_code,
    output logic               evt_txdone,
    output logic               evt_underflow,
    output logic               evt_stopped
);
    txs_e   cur_q;
    txs_e   nxt_c;
    logic   uflow_c;
    txin_t  in_c;
    txevt_t evt_q;

    assign in_c = '{run_en:    run_en,
                    poll_wr:   poll_wr,
                    fetch_ack: fetch_ack,
                    fetch_own: fetch_own,
                    rd_ack:    rd_ack,
                    rd_uflow:  rd_uflow,
                    tx_done:   tx_done};

    txdma_next u_next (
        .cur       (cur_q),
        .in        (in_c),
        .nxt       (nxt_c),
        .uflow_hit (uflow_c)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= TXS_STOP;
        else     cur_q <= nxt_c;
    end

    txdma_events u_evt (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur_q),
        .nxt       (nxt_c),
        .uflow_hit (uflow_c),
        .evt       (evt_q)
    );

    assign state_code    = cur_q;
    assign fetch_req     = (cur_q == TXS_FETCH);
    assign rd_req        = (cur_q == TXS_READ);
    assign evt_txdone    = evt_q.txdone;
    assign evt_underflow = evt_q.underflow;
    assign evt_stopped   = evt_q.stopped;
endmodule

// File: rtl/txdma_chk.sv
module txdma_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic       poll_wr,
    input logic       fetch_ack,
    input logic       fetch_own,
    input logic       rd_uflow,
    input logic       tx_done,
    input logic [2:0] state_code,
    input logic       evt_txdone,
    input logic       evt_underflow,
    input logic       evt_stopped
);
    AST_RESET_STOP: assert property (@(posedge clk) rst |=> (state_code == 3'd0 && !evt_stopped)); // R1
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        (state_code != 3'd4 && state_code != 3'd5)); // R1
    AST_START_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0 && run_en) |=> state_code == 3'd1); // R2
    AST_OWN_READ: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1 && fetch_ack && fetch_own) |=> state_code == 3'd3); // R3
    AST_HOST_SUSP: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1 && fetch_ack && !fetch_own) |=> state_code == 3'd6); // R4
    AST_UFLOW_SUSP: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd3 && rd_uflow) |=> (state_code == 3'd6 && evt_underflow)); // R5
    AST_DONE_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd2 && tx_done) |=> state_code == 3'd7); // R6
    AST_CLOSE_ONCE: assert property (@(posedge clk) disable iff (rst)
        state_code == 3'd7 |=> state_code != 3'd7); // R7
    AST_NO_MIDSTOP: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd3 || state_code == 3'd2) |=> state_code != 3'd0); // R8
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd6 && run_en && !poll_wr) |=> state_code == 3'd6); // R9
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_stopped |-> state_code == 3'd0); // R10
endmodule

bind txdma_seq txdma_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .run_en        (run_en),
    .poll_wr       (poll_wr),
    .fetch_ack     (fetch_ack),
    .fetch_own     (fetch_own),
    .rd_uflow      (rd_uflow),
    .tx_done       (tx_done),
    .state_code    (state_code),
    .evt_txdone    (evt_txdone),
    .evt_underflow (evt_underflow),
    .evt_stopped   (evt_stopped)
);

// File: tb/tb_txdma_seq.sv
module tb_txdma_seq;
    localparam int CLK_P    = 10;
    localparam int N_RAND   = 4000;
    localparam int WD_LIMIT = 20000;

    localparam logic [2:0] S_STOP = 3'd0, S_FETCH = 3'd1, S_WAIT = 3'd2,
                           S_READ = 3'd3, S_SUSP = 3'd6, S_CLOSE = 3'd7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 0, poll_wr = 0, fetch_ack = 0, fetch_own = 0;
    logic rd_ack = 0, rd_uflow = 0, tx_done = 0;
    logic fetch_req, rd_req, evt_txdone, evt_underflow, evt_stopped;
    logic [2:0] state_code;

    int total = 0;
    int bad   = 0;
    logic [2:0] exp_st = S_STOP;

    always #(CLK_P/2) clk = ~clk;

    txdma_seq dut (
        .clk(clk), .rst(rst), .run_en(run_en), .poll_wr(poll_wr),
        .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_own(fetch_own),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_uflow(rd_uflow), .tx_done(tx_done),
        .state_code(state_code), .evt_txdone(evt_txdone),
        .evt_underflow(evt_underflow), .evt_stopped(evt_stopped)
    );

    function automatic logic [2:0] model_next(input logic [2:0] s, input logic re, pw, fa, fo, ra, ru, td);
        case (s)
            S_STOP:  return re ? S_FETCH : S_STOP;
            S_FETCH: return fa ? (fo ? S_READ : S_SUSP) : (re ? S_FETCH : S_STOP);
            S_READ:  return ru ? S_SUSP : (ra ? S_WAIT : S_READ);
            S_WAIT:  return td ? S_CLOSE : S_WAIT;
            S_CLOSE: return re ? S_FETCH : S_STOP;
            S_SUSP:  return !re ? S_STOP : (pw ? S_FETCH : S_SUSP);
            default: return S_STOP;
        endcase
    endfunction

    function automatic string state_tag(input logic [2:0] s, input logic re, fa, fo);
        case (s)
            S_STOP:  return "R2";
            S_FETCH: return (fa && !fo) ? "R4" : (!fa && !re) ? "R8" : "R3";
            S_READ:  return re ? "R5" : "R8";
            S_WAIT:  return "R6";
            S_CLOSE: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, re, pw, fa, fo, ra, ru, td);
        logic [2:0] nx;
        logic e_uf, e_st, e_td;
        string tg;
        @(negedge clk);
        rst = r; run_en = re; poll_wr = pw; fetch_ack = fa; fetch_own = fo;
        rd_ack = ra; rd_uflow = ru; tx_done = td;
        if (r) begin
            nx = S_STOP; e_uf = 0; e_st = 0; e_td = 0; tg = "R1";
        end else begin
            nx   = model_next(exp_st, re, pw, fa, fo, ra, ru, td);
            e_uf = (exp_st == S_READ) && ru;
            e_st = (exp_st != S_STOP) && (nx == S_STOP);
            e_td = (nx == S_CLOSE);
            tg   = state_tag(exp_st, re, fa, fo);
        end
        @(posedge clk);
        #1;
        exp_st = nx;
        check(tg,   "state_code",    int'(state_code),    int'(nx));
        check("R3", "fetch_req",     int'(fetch_req),     int'(nx == S_FETCH));
        check("R5", "rd_req",        int'(rd_req),        int'(nx == S_READ));
        check("R5", "evt_underflow", int'(evt_underflow), int'(e_uf));
        check("R7", "evt_txdone",    int'(evt_txdone),    int'(e_td));
        check("R10","evt_stopped",   int'(evt_stopped),   int'(e_st));
    endtask

    initial begin
        #(CLK_P * WD_LIMIT);
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic unused;
        unused = $urandom(32'h5eed_0042);
        // R1: reset state
        step(1,0,0,0,0,0,0,0);
        step(1,1,1,1,1,1,1,1);
        // R2: stays stopped, then starts
        step(0,0,1,0,0,0,0,0);
        step(0,1,0,0,0,0,0,0);
        // R3, R5, R6, R7: normal frame with poll_wr ignored mid-frame (R9)
        step(0,1,0,1,1,0,0,0);
        step(0,1,1,0,0,0,0,0);
        step(0,1,0,0,0,1,0,0);
        step(0,1,1,0,0,0,0,0);
        step(0,1,0,0,0,0,0,1);
        step(0,1,0,0,0,0,0,0);
        // R4 host-owned, R9 hold then poll
        step(0,1,0,1,0,0,0,0);
        step(0,1,0,0,0,0,0,0);
        step(0,1,1,0,0,0,0,0);
        // R5 underflow beats rd_ack
        step(0,1,0,1,1,0,0,0);
        step(0,1,0,0,0,1,1,0);
        step(0,0,0,0,0,0,0,0);
        // R8 stop mid-frame waits for close
        step(0,1,0,0,0,0,0,0);
        step(0,1,0,1,1,0,0,0);
        step(0,0,0,0,0,0,0,0);
        step(0,0,0,0,0,1,0,0);
        step(0,0,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,1);
        step(0,0,0,0,0,0,0,0);
        // R8 stop during fetch; R10 no pulse on reset of a running engine
        step(0,1,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0,0);
        step(1,1,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,0);
        for (int i = 0; i < N_RAND; i++) begin
            step(($urandom % 200) == 0,
                 ($urandom % 10) != 0,
                 ($urandom % 5) == 0,
                 ($urandom % 5) < 2,
                 ($urandom % 5) != 0,
                 ($urandom % 5) < 2,
                 ($urandom % 10) == 0,
                 ($urandom % 5) < 2);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule